// File: doc/BRIEF.md
# Dual-Output Level-Sensitive Interrupt Controller

This block collects up to 32 interrupt lines and presents them to a processor on two request outputs and one wakeup output. Every source has seven control bits: mask, wakeup enable, source enable, output route, and a three-bit trigger code. Software never writes these bits directly. Each field has one write-one-to-set offset and one write-one-to-clear offset. A write therefore changes only the sources whose data bits are 1, and no read-modify-write sequence is needed.

Each source is evaluated as active-high or active-low level according to its trigger code. Every other code counts as disabled. A source contributes to the request output chosen by its route bit only when it is enabled and unmasked. Software reads two pending status words, one per output, to find which sources are requesting. A system that needs 64 sources instantiates the block twice. The two instances together provide four request lines.

Top module: `dual_req_intc`

## Requirements
- R1: After reset, every control field, the test register and both status words read 0, and `req0_o`, `req1_o` and `wake_o` are low.
- R2: A write to a field's set offset (word offset 2*f, with f = mask 0, wake 1, enable 2, route 3, cfg0 4, cfg1 5, cfg2 6) sets each bit that is 1 in the data and leaves every other bit unchanged. A read at that offset returns the field.
- R3: A write to a field's clear offset (2*f+1) clears each bit that is 1 in the data and leaves every other bit unchanged. Clear offsets read as 0.
- R4: Trigger code {cfg2,cfg1,cfg0} = 3'b101 makes the source active while its synchronized input is 1.
- R5: Trigger code 3'b110 makes the source active while its synchronized input is 0.
- R6: Every other trigger code (000, 001, 010, 011, 100, 111) never makes the source active, at either input level.
- R7: A source with mask bit 0 never requests. Clearing the mask keeps its other fields, and setting the mask again restores the request.
- R8: An active source with route bit 1 appears in status 0 (offset 16) and drives `req0_o`. With route bit 0 it appears in status 1 (offset 17) and drives `req1_o`. Each request output is the OR of its status word.
- R9: A source with enable bit 0 never requests, whatever its trigger code and input level.
- R10: `wake_o` is high exactly when some active, unmasked source has its wakeup bit set.
- R11: A change on `irq_i` reaches the status words and outputs on the third rising clock edge after the change, through two synchronizer stages and one pending register. A control write reaches them on the edge after the write edge.
- R12: Offset 18 reads the mask field. Offset 14 is a read/write test register that has no effect on requests. All other unused offsets read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (5) | Word offset |
| bus_wdata | input | NUM_SRC (32) | Write data, one bit per source |
| bus_rdata | output | NUM_SRC (32) | Read data, valid in the same cycle as `bus_re` |
| irq_i | input | NUM_SRC (32) | Asynchronous interrupt source levels |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wakeup request for idle exit |

## Verification
A corrupted control bit shows up on the request outputs, and in a status word, on the edge after the write that should have set or cleared it, provided the affected source has its input at the active level. A corrupted bit also shows up at once when the field is read back. A wrong synchronizer depth moves the point where a request rises to one edge earlier or later than the third edge, and the latency check looks for that exact edge. A wrong trigger decode or route decode places a source's bit in the wrong status word, or leaves it out. This is visible within four cycles of any input or configuration change in the random sequence.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    // control field indices; set offset = 2*index, clear offset = 2*index+1
    localparam int F_MASK  = 0;
    localparam int F_WAKE  = 1;
    localparam int F_EN    = 2;
    localparam int F_ROUTE = 3;
    localparam int F_C0    = 4;
    localparam int F_C1    = 5;
    localparam int F_C2    = 6;
    localparam int NUM_FIELDS = 7;

    localparam int OFS_TEST    = 2 * NUM_FIELDS;
    localparam int OFS_STAT0   = 16;
    localparam int OFS_STAT1   = 17;
    localparam int OFS_MASK_RD = 18;

    localparam logic [2:0] CODE_HIGH = 3'b101;
    localparam logic [2:0] CODE_LOW  = 3'b110;

    function automatic logic level_hit(input logic [2:0] code, input logic lvl);
        case (code)
            CODE_HIGH: level_hit = lvl;
            CODE_LOW:  level_hit = ~lvl;
            default:   level_hit = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/intc_sync.sv
`timescale 1ns/1ps
module intc_sync #(
    parameter int NUM_SRC = 32,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] async_i,
    output logic [NUM_SRC-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][NUM_SRC-1:0] pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.pipe[k] = s_q.pipe[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.pipe[STAGES-1];
endmodule

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs import intc_pkg::*; #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we_i,
    input  logic                                 re_i,
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic [NUM_SRC-1:0]                   wdata_i,
    input  logic [NUM_SRC-1:0]                   stat0_i,
    input  logic [NUM_SRC-1:0]                   stat1_i,
    output logic [NUM_SRC-1:0]                   rdata_o,
    output logic [NUM_FIELDS-1:0][NUM_SRC-1:0]   fld_o
);
    typedef struct packed {
        logic [NUM_FIELDS-1:0][NUM_SRC-1:0] fld;
        logic [NUM_SRC-1:0]                 test;
    } regs_t;

    regs_t r_d, r_q;
    logic [NUM_SRC-1:0] rdata_d;

    always_comb begin
        r_d     = r_q;
        rdata_d = '0;
        if (we_i) begin
            for (int f = 0; f < NUM_FIELDS; f++) begin
                if (addr_i == ADDR_W'(2 * f))     r_d.fld[f] = r_q.fld[f] | wdata_i;
                if (addr_i == ADDR_W'(2 * f + 1)) r_d.fld[f] = r_q.fld[f] & ~wdata_i;
            end
            if (addr_i == ADDR_W'(OFS_TEST)) r_d.test = wdata_i;
        end
        if (re_i) begin
            for (int f = 0; f < NUM_FIELDS; f++) begin
                if (addr_i == ADDR_W'(2 * f)) rdata_d = r_q.fld[f];
            end
            if (addr_i == ADDR_W'(OFS_TEST))    rdata_d = r_q.test;
            if (addr_i == ADDR_W'(OFS_STAT0))   rdata_d = stat0_i;
            if (addr_i == ADDR_W'(OFS_STAT1))   rdata_d = stat1_i;
            if (addr_i == ADDR_W'(OFS_MASK_RD)) rdata_d = r_q.fld[F_MASK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata_o = rdata_d;
    assign fld_o   = r_q.fld;
endmodule

// File: rtl/intc_pend.sv
`timescale 1ns/1ps
module intc_pend import intc_pkg::*; #(
    parameter int NUM_SRC = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_SRC-1:0]                 lvl_i,
    input  logic [NUM_FIELDS-1:0][NUM_SRC-1:0] fld_i,
    output logic [NUM_SRC-1:0]                 stat0_o,
    output logic [NUM_SRC-1:0]                 stat1_o,
    output logic                               req0_o,
    output logic                               req1_o,
    output logic                               wake_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] st0;
        logic [NUM_SRC-1:0] st1;
        logic               req0;
        logic               req1;
        logic               wake;
    } pend_t;

    pend_t p_d, p_q;
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = level_hit({fld_i[F_C2][i], fld_i[F_C1][i], fld_i[F_C0][i]}, lvl_i[i]);
    end

    always_comb begin
        logic [NUM_SRC-1:0] act;
        act        = hit & fld_i[F_EN] & fld_i[F_MASK];
        p_d.st0    = act & fld_i[F_ROUTE];
        p_d.st1    = act & ~fld_i[F_ROUTE];
        p_d.req0   = |p_d.st0;
        p_d.req1   = |p_d.st1;
        p_d.wake   = |(act & fld_i[F_WAKE]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign stat0_o = p_q.st0;
    assign stat1_o = p_q.st1;
    assign req0_o  = p_q.req0;
    assign req1_o  = p_q.req1;
    assign wake_o  = p_q.wake;
endmodule

// File: rtl/dual_req_intc.sv
`timescale 1ns/1ps
module dual_req_intc import intc_pkg::*; #(
    parameter int NUM_SRC     = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] irq_i,
    output logic               req0_o,
    output logic               req1_o,
    output logic               wake_o
);
    logic [NUM_FIELDS-1:0][NUM_SRC-1:0] fld_w;
    logic [NUM_SRC-1:0] lvl_w, st0_w, st1_w;
    logic [NUM_SRC-1:0] mask_w, en_w, route_w, c0_w, c1_w, c2_w;

    intc_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(irq_i), .sync_o(lvl_w)
    );

    intc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .re_i(bus_re),
        .addr_i(bus_addr), .wdata_i(bus_wdata),
        .stat0_i(st0_w), .stat1_i(st1_w),
        .rdata_o(bus_rdata), .fld_o(fld_w)
    );

    intc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w), .fld_i(fld_w),
        .stat0_o(st0_w), .stat1_o(st1_w),
        .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
    );

    assign mask_w  = fld_w[F_MASK];
    assign en_w    = fld_w[F_EN];
    assign route_w = fld_w[F_ROUTE];
    assign c0_w    = fld_w[F_C0];
    assign c1_w    = fld_w[F_C1];
    assign c2_w    = fld_w[F_C2];
endmodule

// File: rtl/intc_checker.sv
`timescale 1ns/1ps
module intc_checker #(
    parameter int NUM_SRC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req0,
    input logic               req1,
    input logic               wake,
    input logic [NUM_SRC-1:0] st0,
    input logic [NUM_SRC-1:0] st1,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] route,
    input logic [NUM_SRC-1:0] c0,
    input logic [NUM_SRC-1:0] c1,
    input logic [NUM_SRC-1:0] c2
);
    logic [NUM_SRC-1:0] valid_code;
    assign valid_code = (c2 & ~c1 & c0) | (c2 & c1 & ~c0);

    // R1: outputs stay low while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!req0 && !req1 && !wake && st0 == '0 && st1 == '0);
        end
    end

    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st0 | st1) & ~$past(mask)) == '0));

    a_r9_enable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st0 | st1) & ~$past(en)) == '0));

    a_r6_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st0 | st1) & ~$past(valid_code)) == '0));

    a_r8_route_steer: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st0 & ~$past(route)) == '0) && ((st1 & $past(route)) == '0)));

    a_r10_wake_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (req0 || req1));
endmodule

bind dual_req_intc intc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .req0(req0_o), .req1(req1_o), .wake(wake_o),
    .st0(st0_w), .st1(st1_w), .mask(mask_w), .en(en_w), .route(route_w),
    .c0(c0_w), .c1(c1_w), .c2(c2_w)
);

// File: tb/sim_dual_req_intc.sv
`timescale 1ns/1ps
module sim_dual_req_intc;
    localparam int N = 32;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0, re = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [N-1:0] wdata = '0, rdata, irq = '0;
    logic req0, req1, wake;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [N-1:0] m_f [7];
    logic [N-1:0] m_test;

    always #5 clk = ~clk;

    dual_req_intc #(.NUM_SRC(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_i(irq),
        .req0_o(req0), .req1_o(req1), .wake_o(wake)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [N-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
        if (a < 14) begin
            if (a % 2 == 0) m_f[a/2] = m_f[a/2] | d;
            else            m_f[a/2] = m_f[a/2] & ~d;
        end else if (a == 14) begin
            m_test = d;
        end
    endtask

    task automatic rd(input int a, output logic [N-1:0] d);
        re = 1'b1; addr = AW'(a);
        #1 d = rdata;
        re = 1'b0;
    endtask

    function automatic logic [N-1:0] exp_act();
        return m_f[2] & m_f[0] &
               ((m_f[6] & ~m_f[5] & m_f[4] & irq) | (m_f[6] & m_f[5] & ~m_f[4] & ~irq));
    endfunction

    function automatic logic [N-1:0] exp_rd(input int a);
        if (a < 14)  return (a % 2 == 0) ? m_f[a/2] : '0;
        if (a == 14) return m_test;
        if (a == 16) return exp_act() & m_f[3];
        if (a == 17) return exp_act() & ~m_f[3];
        if (a == 18) return m_f[0];
        return '0;
    endfunction

    task automatic check_all(input string tag);
        logic [N-1:0] v;
        rd(16, v); check({tag, " R8 status0"}, v, exp_rd(16));
        rd(17, v); check({tag, " R8 status1"}, v, exp_rd(17));
        check({tag, " R8 req0"}, N'(req0), N'(|exp_rd(16)));
        check({tag, " R8 req1"}, N'(req1), N'(|exp_rd(17)));
        check({tag, " R10 wake"}, N'(wake), N'(|(exp_act() & m_f[1])));
    endtask

    task automatic clear_all();
        for (int f = 0; f < 7; f++) wr(2*f+1, '1);
        irq = '0;
        idle(4);
    endtask

    // program one source: code bits, route, enable, mask
    task automatic prog(input int s, input logic [2:0] code, input logic rt);
        logic [N-1:0] b;
        b = N'(1) << s;
        wr(9, b); wr(11, b); wr(13, b);
        if (code[0]) wr(8, b);
        if (code[1]) wr(10, b);
        if (code[2]) wr(12, b);
        if (rt) wr(6, b); else wr(7, b);
        wr(4, b); wr(0, b);
    endtask

    initial begin
        logic [N-1:0] v;
        for (int f = 0; f < 7; f++) m_f[f] = '0;
        m_test = '0;
        void'($urandom(32'd4711));
        idle(3);
        // R1 reset state
        check("R1 req0", N'(req0), '0);
        check("R1 req1", N'(req1), '0);
        check("R1 wake", N'(wake), '0);
        rst_n = 1'b1;
        idle(2);
        for (int a = 0; a < 19; a++) begin
            rd(a, v);
            check($sformatf("R1 read offset %0d", a), v, '0);
        end

        // R2 / R3 set and clear touch only the written ones
        wr(2, 32'hF0F0_0F0F);
        wr(2, 32'h0000_00F0);
        rd(2, v); check("R2 set preserves", v, 32'hF0F0_0FFF);
        wr(3, 32'h0000_0F00);
        rd(2, v); check("R3 clear preserves", v, 32'hF0F0_00FF);
        rd(3, v); check("R3 clear offset reads zero", v, '0);
        wr(3, '1);

        // R12 test register, mask readback, unused offsets
        wr(14, 32'hDEAD_BEEF);
        rd(14, v); check("R12 test reg", v, 32'hDEAD_BEEF);
        wr(15, '1); wr(19, '1);
        rd(15, v); check("R12 unused 15", v, '0);
        rd(19, v); check("R12 unused 19", v, '0);
        rd(31, v); check("R12 unused 31", v, '0);
        wr(0, 32'h0000_8001);
        rd(18, v); check("R12 mask read", v, 32'h0000_8001);
        irq = '1; idle(4);
        check("R12 test reg no effect", N'(req0 | req1 | wake), '0);
        clear_all();
        wr(14, '0);

        // R4 R5 R6: every code at both levels, source 2 routed to output 1
        for (int c = 0; c < 8; c++) begin
            prog(2, 3'(c), 1'b0);
            for (int l = 0; l < 2; l++) begin
                irq = N'(l) << 2;
                idle(4);
                check($sformatf("%s code %0d lvl %0d", (c == 5) ? "R4" : (c == 6) ? "R5" : "R6", c, l),
                      N'(req1), N'((c == 5 && l == 1) || (c == 6 && l == 0)));
                check("R8 req0 idle", N'(req0), '0);
            end
        end
        clear_all();

        // R7 mask blocks and keeps configuration
        prog(5, 3'b101, 1'b1);
        irq = N'(1) << 5; idle(4);
        check("R7 unmasked requests", N'(req0), 1);
        wr(1, N'(1) << 5); idle(2);
        check("R7 masked blocked", N'(req0), 0);
        rd(12, v); check("R7 config kept", v, N'(1) << 5);
        wr(0, N'(1) << 5); idle(2);
        check("R7 restored", N'(req0), 1);
        check_all("R8 route1");

        // R9 enable blocks
        wr(5, N'(1) << 5); idle(2);
        check("R9 enable off", N'(req0), 0);
        wr(4, N'(1) << 5); idle(2);

        // R10 wake follows wake enable
        check("R10 wake off", N'(wake), 0);
        wr(2, N'(1) << 5); idle(2);
        check("R10 wake on", N'(wake), 1);
        clear_all();

        // R11 latency: input path and control write path
        prog(3, 3'b101, 1'b1);
        idle(4);
        @(negedge clk); irq = N'(1) << 3;
        @(negedge clk); @(negedge clk);
        check("R11 not yet after two edges", N'(req0), 0);
        @(negedge clk);
        check("R11 third edge", N'(req0), 1);
        wr(1, N'(1) << 3);
        check("R11 write not before next edge", N'(req0), 1);
        @(negedge clk);
        check("R11 write reflected", N'(req0), 0);
        clear_all();

        // random mix
        for (int it = 0; it < 400; it++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 7) begin
                int a;
                a = int'($urandom % 16);
                wr(a, (a >= 8 && a < 14 && ($urandom % 2 == 1)) ? ($urandom & $urandom) : $urandom);
            end else begin
                irq = $urandom;
            end
            idle(4);
            check_all("R4 R5 random");
            begin
                int a2;
                a2 = int'($urandom % 20);
                rd(a2, v);
                check($sformatf("R2 R3 R12 random read %0d", a2), v, exp_rd(a2));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule